// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves bytes between a 32-bit word memory and a byte-wide device FIFO. It does this by following a linked list of descriptors held in memory. Each descriptor is three consecutive words:

- a buffer address;
- a count-and-flags word;
- a pointer to the next descriptor.

Software writes the address of the first descriptor, picks transmit or receive and a byte order, and starts the channel. The engine then fetches descriptors, packs or unpacks memory words four bytes at a time and counts bytes down to zero. On transmit it writes a sent flag back into each descriptor. It stops after the descriptor that carries the end-of-chain flag.

Software observes progress through one control/status word. That word reads back an active flag and an interrupt flag, and the interrupt flag clears when it is read. The memory side is a plain request/grant port. The engine holds a request until it is granted, and read data is valid in the grant cycle.

Top module: `dma_chain_engine`

## Requirements
- R1: A descriptor at pointer P is fetched as three word reads at P (buffer address), P+4 (count/flags) and P+8 (next pointer). A memory request holds its address and direction until granted.
- R2: On transmit, the buffer's bytes leave on the valid/ready FIFO port in buffer order. With the byte-order select at 0 (big-endian), byte 0 of a word is bits 31:24. With it at 1 (little-endian), byte 0 is bits 7:0. Data holds steady while valid waits for ready.
- R3: On receive, incoming bytes are packed into words in the selected byte order and written to consecutive buffer words. A final partial word is written with zeros in its unfilled byte lanes.
- R4: After each buffer, the descriptor pointer (read at select 1) is loaded from the third descriptor word. If bit 31 of the count/flags word is set, the pointer is not loaded, the channel stops and the active flag clears. No memory request is made while the channel is inactive.
- R5: A byte count (bits 13:0) of zero moves no data. The engine makes no access to that buffer and goes on to the next descriptor.
- R6: When bit 30 of the count/flags word is set, the end-of-packet strobe accompanies the last transmitted byte of that buffer, and no other byte. When bit 30 is clear, the strobe is never raised.
- R7: Bit 29 of the count/flags word sets the interrupt flag (read bit 0 at select 0) once that buffer completes. A read of the control word returns the flag and clears it on the following edge.
- R8: On transmit, the engine writes the count/flags word back with bit 15 set after the buffer's bytes are sent. On receive, no write-back occurs.
- R9: A control write (select 0) starts the channel only when write bit 4 (start) and bit 5 (load enable) are both 1. Bit 2 selects receive and bit 1 selects little-endian. Control and pointer writes are ignored while the channel is active.
- R10: After reset, the control word reads 0, the pointer reads 0, and no memory request or FIFO valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (clears interrupt on control read) |
| csr_sel | input | 1 | 0 = control/status word, 1 = descriptor pointer |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access granted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| dev_tx_valid | output | 1 | Transmit byte valid |
| dev_tx_ready | input | 1 | Device accepts transmit byte |
| dev_tx_data | output | 8 | Transmit byte |
| dev_tx_eop | output | 1 | Transmit byte ends a packet |
| dev_rx_valid | input | 1 | Receive byte valid |
| dev_rx_ready | output | 1 | Engine accepts receive byte |
| dev_rx_data | input | 8 | Receive byte |

## Verification
Register writes take effect on the edge that samples them. A start raises the first descriptor request in the next cycle. Read data is combinational, and the interrupt clear lands on the edge that ends the read cycle.

FIFO bytes move on the edge where valid and ready are both high. The bench therefore compares each byte against its queue of expected bytes at the falling edge just before that handshake edge.

Active, interrupt and the pointer change on the edge that leaves the completion state. That edge comes after the write-back grant, whose timing depends on memory latency. The bench therefore waits until its byte queues drain, adds a fixed margin longer than any write-back, and only then reads the registers and the memory image.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_DBUF, SQ_DCNT, SQ_DNXT, SQ_RD, SQ_TX, SQ_RX, SQ_WR, SQ_WB, SQ_END
  } seq_state_e;

  // count/flags word bit positions
  localparam int CF_LAST = 31;
  localparam int CF_EOP  = 30;
  localparam int CF_IRQ  = 29;
  localparam int CF_SENT = 15;

  // control write bit positions
  localparam int CW_LITTLE = 1;
  localparam int CW_RX     = 2;
  localparam int CW_START  = 4;
  localparam int CW_LOAD   = 5;

  function automatic logic [1:0] lane_shift(input logic [1:0] lane, input logic little);
    return little ? lane : ~lane;
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] lane,
                                           input logic little);
    logic [1:0] sh;
    sh = lane_shift(lane, little);
    return w[{sh, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] lane,
                                           input logic little, input logic [7:0] b);
    logic [31:0] r;
    logic [1:0]  sh;
    r  = w;
    sh = lane_shift(lane, little);
    r[{sh, 3'b000} +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/dma_chain_csr.sv
module dma_chain_csr
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic          sel,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          go,
  output logic          active,
  output logic          irq,
  output logic          little,
  output logic          rx_dir,
  output logic [AW-1:0] ptr,
  input  logic          done_evt,
  input  logic          done_irq,
  input  logic          done_last,
  input  logic [AW-1:0] done_next
);

  logic accept;
  assign accept = wr && !active;
  assign go     = accept && !sel && wdata[CW_START] && wdata[CW_LOAD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      irq    <= 1'b0;
      little <= 1'b0;
      rx_dir <= 1'b0;
      ptr    <= '0;
    end else begin
      if (accept && !sel) begin
        little <= wdata[CW_LITTLE];
        rx_dir <= wdata[CW_RX];
        if (go) active <= 1'b1;
      end
      if (accept && sel) ptr <= wdata[AW-1:0];
      if (done_evt) begin
        if (done_last) active <= 1'b0;
        else           ptr    <= done_next;
      end
      if (done_evt && done_irq) irq <= 1'b1;
      else if (rd && !sel)      irq <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[AW-1:0] = ptr;
    else     rdata[1:0]    = {active, irq};
  end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          little,
  input  logic          rx_dir,
  input  logic [AW-1:0] desc_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          dev_tx_valid,
  input  logic          dev_tx_ready,
  output logic [7:0]    dev_tx_data,
  output logic          dev_tx_eop,
  input  logic          dev_rx_valid,
  output logic          dev_rx_ready,
  input  logic [7:0]    dev_rx_data,
  output logic          done_evt,
  output logic          done_irq,
  output logic          done_last,
  output logic [AW-1:0] done_next
);

  localparam logic [AW-1:0] WORD_STEP = AW'(4);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  seq_state_e       st;
  logic [AW-1:0]    buf_addr, nxt;
  logic [31:0]      cnt_word, word;
  logic [CNT_W-1:0] remain;
  logic [1:0]       lane;
  logic             cnt_zero, tx_beat, rx_beat, last_byte;

  assign cnt_zero  = (cnt_word[CNT_W-1:0] == '0);
  assign last_byte = (remain == ONE);
  assign tx_beat   = dev_tx_valid && dev_tx_ready;
  assign rx_beat   = dev_rx_valid && dev_rx_ready;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      SQ_DBUF: begin mem_req = 1'b1; mem_addr = desc_ptr; end
      SQ_DCNT: begin mem_req = 1'b1; mem_addr = desc_ptr + WORD_STEP; end
      SQ_DNXT: begin mem_req = 1'b1; mem_addr = desc_ptr + (WORD_STEP << 1); end
      SQ_RD:   begin mem_req = 1'b1; mem_addr = {buf_addr[AW-1:2], 2'b00}; end
      SQ_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {buf_addr[AW-1:2], 2'b00}; mem_wdata = word;
      end
      SQ_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_ptr + WORD_STEP;
        mem_wdata = cnt_word | (32'd1 << CF_SENT);
      end
      default: ;
    endcase
  end

  assign dev_tx_valid = (st == SQ_TX);
  assign dev_tx_data  = lane_pick(word, lane, little);
  assign dev_tx_eop   = dev_tx_valid && cnt_word[CF_EOP] && last_byte;
  assign dev_rx_ready = (st == SQ_RX);

  assign done_evt  = (st == SQ_END);
  assign done_irq  = cnt_word[CF_IRQ];
  assign done_last = cnt_word[CF_LAST];
  assign done_next = nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      buf_addr <= '0;
      nxt      <= '0;
      cnt_word <= '0;
      word     <= '0;
      remain   <= '0;
      lane     <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (go) st <= SQ_DBUF;
        SQ_DBUF: if (mem_gnt) begin buf_addr <= mem_rdata[AW-1:0]; st <= SQ_DCNT; end
        SQ_DCNT: if (mem_gnt) begin cnt_word <= mem_rdata; st <= SQ_DNXT; end
        SQ_DNXT: if (mem_gnt) begin
          nxt    <= mem_rdata[AW-1:0];
          remain <= cnt_word[CNT_W-1:0];
          lane   <= '0;
          word   <= '0;
          if (cnt_zero) st <= rx_dir ? SQ_END : SQ_WB;
          else          st <= rx_dir ? SQ_RX  : SQ_RD;
        end
        SQ_RD: if (mem_gnt) begin
          word     <= mem_rdata;
          lane     <= '0;
          buf_addr <= buf_addr + WORD_STEP;
          st       <= SQ_TX;
        end
        SQ_TX: if (tx_beat) begin
          remain <= remain - ONE;
          lane   <= lane + 2'd1;
          if (last_byte)         st <= SQ_WB;
          else if (lane == 2'd3) st <= SQ_RD;
        end
        SQ_RX: if (rx_beat) begin
          word   <= lane_put(word, lane, little, dev_rx_data);
          remain <= remain - ONE;
          lane   <= lane + 2'd1;
          if (last_byte || lane == 2'd3) st <= SQ_WR;
        end
        SQ_WR: if (mem_gnt) begin
          buf_addr <= buf_addr + WORD_STEP;
          word     <= '0;
          lane     <= '0;
          st       <= (remain == '0) ? SQ_END : SQ_RX;
        end
        SQ_WB:   if (mem_gnt) st <= SQ_END;
        SQ_END:  st <= cnt_word[CF_LAST] ? SQ_IDLE : SQ_DBUF;
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int AW    = 32,
  parameter int CNT_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_wr,
  input  logic          csr_rd,
  input  logic          csr_sel,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          dev_tx_valid,
  input  logic          dev_tx_ready,
  output logic [7:0]    dev_tx_data,
  output logic          dev_tx_eop,
  input  logic          dev_rx_valid,
  output logic          dev_rx_ready,
  input  logic [7:0]    dev_rx_data
);

  // named internal events, also observed by the checker
  logic          start_go, run_active, irq_flag, little, rx_dir;
  logic          desc_done, desc_irq, desc_last;
  logic [AW-1:0] desc_ptr, desc_next;

  dma_chain_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(csr_wr), .rd(csr_rd), .sel(csr_sel),
    .wdata(csr_wdata), .rdata(csr_rdata), .go(start_go), .active(run_active),
    .irq(irq_flag), .little(little), .rx_dir(rx_dir), .ptr(desc_ptr),
    .done_evt(desc_done), .done_irq(desc_irq), .done_last(desc_last),
    .done_next(desc_next)
  );

  dma_chain_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start_go), .little(little), .rx_dir(rx_dir),
    .desc_ptr(desc_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_tx_data(dev_tx_data), .dev_tx_eop(dev_tx_eop),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
    .dev_rx_data(dev_rx_data), .done_evt(desc_done), .done_irq(desc_irq),
    .done_last(desc_last), .done_next(desc_next)
  );

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_wr,
  input logic          csr_rd,
  input logic          csr_sel,
  input logic          wr_load,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          dev_tx_valid,
  input logic          dev_tx_ready,
  input logic [7:0]    dev_tx_data,
  input logic          dev_tx_eop,
  input logic          dev_rx_ready,
  input logic          run_active,
  input logic          irq_flag,
  input logic          desc_done
);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));

  // R3
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_tx_valid && dev_rx_ready));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run_active);

  // R6
  eop_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_eop |-> dev_tx_valid);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd && !csr_sel && !desc_done |=> !irq_flag);

  // R9
  load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && !csr_sel && !wr_load && !run_active |=> !run_active);

endmodule

bind dma_chain_engine dma_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_sel(csr_sel),
  .wr_load(csr_wdata[5]), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
  .dev_tx_data(dev_tx_data), .dev_tx_eop(dev_tx_eop), .dev_rx_ready(dev_rx_ready),
  .run_active(run_active), .irq_flag(irq_flag), .desc_done(desc_done)
);

// File: tb/sim_dma_chain_engine.sv
module sim_dma_chain_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0, csr_rd = 1'b0, csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        dev_tx_valid, dev_tx_ready = 1'b0, dev_tx_eop;
  logic [7:0]  dev_tx_data;
  logic        dev_rx_valid = 1'b0, dev_rx_ready;
  logic [7:0]  dev_rx_data = '0;

  always #10 clk = ~clk;

  dma_chain_engine u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_tx_eop(dev_tx_eop), .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
    .dev_rx_data(dev_rx_data)
  );

  logic [31:0] mem [0:511];
  bit          rd_seen [0:511];
  logic [8:0]  txq [$];   // {eop, byte}
  logic [7:0]  rxq [$];
  int checks = 0, errors = 0;
  int lat = 0, idx = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: variable grant latency, data with grant
  always @(negedge clk) begin
    if (!rst_n || !mem_req) mem_gnt = 1'b0;
    else if (lat == 0) begin
      mem_gnt = 1'b1;
      idx = int'(mem_addr[10:2]);
      if (mem_we) mem[idx] = mem_wdata;
      else begin mem_rdata = mem[idx]; rd_seen[idx] = 1'b1; end
      lat = int'($urandom % 3);
    end else begin
      mem_gnt = 1'b0;
      lat--;
    end
  end

  // transmit sink, compared against the expected byte queue at each handshake
  always @(negedge clk) begin
    dev_tx_ready = rst_n && ($urandom % 4 != 0);
    if (dev_tx_valid && dev_tx_ready) begin
      if (txq.size() == 0) check(1'b0, "R2 unexpected tx byte", {24'd0, dev_tx_data}, 32'd0);
      else begin
        logic [8:0] e;
        e = txq.pop_front();
        check(dev_tx_data == e[7:0], "R2 tx byte", {24'd0, dev_tx_data}, {24'd0, e[7:0]});
        check(dev_tx_eop == e[8], "R6 tx eop", {31'd0, dev_tx_eop}, {31'd0, e[8]});
      end
    end
  end

  // receive source
  always @(negedge clk) begin
    if (rst_n && rxq.size() != 0 && ($urandom % 3 != 0)) begin
      dev_rx_valid = 1'b1;
      dev_rx_data  = rxq[0];
      if (dev_rx_ready) void'(rxq.pop_front());
    end else dev_rx_valid = 1'b0;
  end

  task automatic csr_write(input logic s, input logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic s, output logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_rd = 1'b1;
    #1 d = csr_rdata;
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  // big-endian byte k of a buffer, computed from the memory image
  function automatic logic [7:0] be_byte(input int base, input int k);
    logic [31:0] w;
    w = mem[(base >> 2) + k / 4];
    return w >> (8 * (3 - k % 4));
  endfunction

  task automatic drain();
    while (txq.size() != 0 || rxq.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R4 watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 512; i++) begin mem[i] = '0; rd_seen[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check(mem_req == 1'b0, "R10 no request", {31'd0, mem_req}, 32'd0);
    check(dev_tx_valid == 1'b0, "R10 no tx valid", {31'd0, dev_tx_valid}, 32'd0);
    csr_read(1'b0, d); check(d == 32'd0, "R10 control", d, 32'd0);
    csr_read(1'b1, d); check(d == 32'd0, "R10 pointer", d, 32'd0);

    // transmit chain, big-endian: A (5 bytes, irq), B (zero count), C (6 bytes, eop, last)
    mem[32'h400 >> 2] = 32'hA1A2A3A4; mem[32'h404 >> 2] = 32'hB1B2B3B4;
    mem[32'h500 >> 2] = 32'hEEEEEEEE;
    mem[32'h600 >> 2] = 32'hC1C2C3C4; mem[32'h604 >> 2] = 32'hD1D2D3D4;
    mem[32'h100 >> 2] = 32'h400; mem[32'h104 >> 2] = 32'h2000_0005; mem[32'h108 >> 2] = 32'h110;
    mem[32'h110 >> 2] = 32'h500; mem[32'h114 >> 2] = 32'h0000_0000; mem[32'h118 >> 2] = 32'h120;
    mem[32'h120 >> 2] = 32'h600; mem[32'h124 >> 2] = 32'hC000_0006; mem[32'h128 >> 2] = 32'h3F0;
    for (int k = 0; k < 5; k++) txq.push_back({1'b0, be_byte(32'h400, k)});
    for (int k = 0; k < 6; k++) txq.push_back({k == 5, be_byte(32'h600, k)});
    csr_write(1'b1, 32'h100);
    csr_write(1'b0, 32'h30);
    csr_write(1'b1, 32'h1F0);   // R9: ignored while active
    drain();
    check(txq.size() == 0, "R2 all bytes sent", txq.size(), 32'd0);
    check(rd_seen[32'h108 >> 2] && rd_seen[32'h128 >> 2], "R1 next word fetched",
          {31'd0, rd_seen[32'h128 >> 2]}, 32'd1);
    check(rd_seen[32'h500 >> 2] == 1'b0, "R5 zero-count buffer untouched",
          {31'd0, rd_seen[32'h500 >> 2]}, 32'd0);
    check(mem[32'h104 >> 2] == 32'h2000_8005, "R8 writeback A", mem[32'h104 >> 2], 32'h2000_8005);
    check(mem[32'h114 >> 2] == 32'h0000_8000, "R8 writeback B", mem[32'h114 >> 2], 32'h0000_8000);
    check(mem[32'h124 >> 2] == 32'hC000_8006, "R8 writeback C", mem[32'h124 >> 2], 32'hC000_8006);
    csr_read(1'b1, d); check(d == 32'h120, "R4 pointer stops at last", d, 32'h120);
    csr_read(1'b0, d); check(d == 32'h1, "R7 irq set, R4 inactive", d, 32'h1);
    csr_read(1'b0, d); check(d == 32'h0, "R7 irq cleared by read", d, 32'h0);

    // receive, little-endian, 7 bytes, irq, last
    mem[32'h700 >> 2] = 32'hFFFFFFFF; mem[32'h704 >> 2] = 32'hFFFFFFFF;
    mem[32'h200 >> 2] = 32'h700; mem[32'h204 >> 2] = 32'hA000_0007; mem[32'h208 >> 2] = 32'h0;
    for (int k = 0; k < 7; k++) rxq.push_back(8'h11 + 8'(k));
    csr_write(1'b1, 32'h200);
    csr_write(1'b0, 32'h36);
    drain();
    check(mem[32'h700 >> 2] == 32'h14131211, "R3 rx word 0", mem[32'h700 >> 2], 32'h14131211);
    check(mem[32'h704 >> 2] == 32'h00171615, "R3 rx partial word", mem[32'h704 >> 2], 32'h00171615);
    check(mem[32'h204 >> 2] == 32'hA000_0007, "R8 no rx writeback", mem[32'h204 >> 2], 32'hA000_0007);
    csr_read(1'b0, d); check(d == 32'h1, "R7 rx irq", d, 32'h1);
    csr_read(1'b0, d); check(d == 32'h0, "R7 rx irq cleared", d, 32'h0);

    // transmit, little-endian, no eop, no irq
    mem[32'h780 >> 2] = 32'h44332211;
    mem[32'h300 >> 2] = 32'h780; mem[32'h304 >> 2] = 32'h8000_0003; mem[32'h308 >> 2] = 32'h0;
    txq.push_back({1'b0, 8'h11}); txq.push_back({1'b0, 8'h22}); txq.push_back({1'b0, 8'h33});
    csr_write(1'b1, 32'h300);
    csr_write(1'b0, 32'h32);
    drain();
    check(mem[32'h304 >> 2] == 32'h8000_8003, "R8 writeback little", mem[32'h304 >> 2], 32'h8000_8003);
    csr_read(1'b0, d); check(d == 32'h0, "R7 no irq without request", d, 32'h0);
    csr_read(1'b1, d); check(d == 32'h300, "R4 pointer single", d, 32'h300);

    // start without load enable
    for (int i = 0; i < 512; i++) rd_seen[i] = 1'b0;
    mem[32'h304 >> 2] = 32'h8000_0003;
    csr_write(1'b0, 32'h10);
    repeat (20) @(negedge clk);
    check(rd_seen[32'h300 >> 2] == 1'b0, "R9 no fetch without load",
          {31'd0, rd_seen[32'h300 >> 2]}, 32'd0);
    csr_read(1'b0, d); check(d == 32'h0, "R9 stays inactive", d, 32'h0);

    summary();
    $finish;
  end

endmodule